// File: doc/BRIEF.md
# Multiplexed Decimal Display Driver

This block shows an unsigned 8-bit number in decimal on four seven-segment digits that share one segment bus. When a load strobe is high on a rising edge of the main clock, a display register takes the value from the data bus. The register keeps that value until the next strobe.

A separate display clock drives a free-running 2-bit digit counter. A decoder turns the counter state into a one-hot enable, so only one digit is lit at any time. The segment pattern is computed combinationally from two inputs: the held value and the current digit index. The split of the binary value into decimal digits therefore happens inside the scan loop.

Digit index 0 is the ones place, index 1 the tens, index 2 the hundreds, and index 3 is always dark. Leading zeros are suppressed.

Top module: `dec_disp_mux`

## Requirements
- R1: While rst_n is low, the held value is 0 and the digit index is 0. So dig_en_o reads 4'b0001 and seg_o reads 7'h3F, the pattern for "0".
- R2: The digit index advances by one on every rising edge of disp_clk, in the order 0, 1, 2, 3, 0. It does not change on edges of clk.
- R3: dig_en_o has exactly one bit set, and that bit is the bit whose position equals the digit index.
- R4: On a rising edge of clk with load_i high, the held value becomes bus_i.
- R5: On a rising edge of clk with load_i low, the held value does not change, whatever bus_i carries.
- R6: At index 0, seg_o shows the value modulo 10. This digit is never blanked, so a value of 0 shows "0".
- R7: At index 1, seg_o shows (value / 10) modulo 10 when the value is 10 or more, and reads 0 (blank) otherwise.
- R8: At index 2, seg_o shows value / 100 when the value is 100 or more, and reads 0 (blank) otherwise.
- R9: At index 3, seg_o always reads 0.
- R10: Segments are active-high. seg_o[0] is segment a through seg_o[6] segment g. Digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the display register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| disp_clk | input | 1 | Display scan clock; drives the digit counter |
| load_i | input | 1 | Display-load strobe |
| bus_i | input | 8 | Data bus value to capture |
| seg_o | output | 7 | Segment drive, bit 0 = a through bit 6 = g, active-high |
| dig_en_o | output | 4 | One-hot digit enable, bit i lights digit i, active-high |

## Verification
Every value from 0 to 255 is loaded in turn and then scanned through all four digit positions.

- Single-digit values show whether tens and hundreds blanking works and whether a zero in the ones place still lights.
- Values from 10 to 99 separate tens blanking from hundreds blanking.
- Values with an interior zero, such as 100 to 109, show that a zero tens digit is displayed once a hundreds digit exists.

After each load, the bus is driven with the bitwise complement of the value while the main clock keeps running, so a missing hold would change the next scan. The digit index is modelled across main-clock activity, which shows that the counter steps only on the display clock.

// File: rtl/dec_disp_mux.sv
module dec_disp_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       disp_clk,
  input  logic       load_i,
  input  logic [7:0] bus_i,
  output logic [6:0] seg_o,
  output logic [3:0] dig_en_o
);

  localparam logic [3:0] BLANK = 4'hF;

  logic [7:0] val_q;
  logic [1:0] idx_q;
  logic [3:0] ones, tens, hund, pick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      val_q <= '0;
    else if (load_i) val_q <= bus_i;

  always_ff @(posedge disp_clk or negedge rst_n)
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_q + 2'd1;

  assign dig_en_o = 4'b0001 << idx_q;

  assign ones = 4'(val_q % 8'd10);
  assign tens = 4'((val_q / 8'd10) % 8'd10);
  assign hund = 4'(val_q / 8'd100);

  always_comb
    case (idx_q)
      2'd0:    pick = ones;
      2'd1:    pick = (val_q >= 8'd10)  ? tens : BLANK;
      2'd2:    pick = (val_q >= 8'd100) ? hund : BLANK;
      default: pick = BLANK;
    endcase

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  assign seg_o = seg7(pick);

  p_load_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> val_q == $past(bus_i));

  p_hold_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(val_q));

  p_scan_rotate_r2: assert property (@(posedge disp_clk) disable iff (!rst_n)
    1'b1 |=> dig_en_o == {$past(dig_en_o[2:0]), $past(dig_en_o[3])});

  p_one_digit_r3: assert property (@(posedge disp_clk) disable iff (!rst_n)
    $countones(dig_en_o) == 1);

  p_top_dark_r9: assert property (@(posedge disp_clk) disable iff (!rst_n)
    dig_en_o[3] |-> seg_o == 7'h00);

  p_ones_lit_r6: assert property (@(posedge disp_clk) disable iff (!rst_n)
    dig_en_o[0] |-> seg_o != 7'h00);

endmodule

// File: tb/dec_disp_mux_bench.sv
module dec_disp_mux_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_clk = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] bus_i = '0;
  logic [6:0] seg_o;
  logic [3:0] dig_en_o;

  int checks = 0;
  int errors = 0;
  int idx_exp = 0;
  bit finished = 1'b0;

  dec_disp_mux u_dec_disp_mux (
    .clk(clk), .rst_n(rst_n), .disp_clk(disp_clk), .load_i(load_i),
    .bus_i(bus_i), .seg_o(seg_o), .dig_en_o(dig_en_o)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input int v, input int i);
    case (i)
      0: return pat(v % 10);
      1: return (v >= 10)  ? pat((v / 10) % 10) : 7'h00;
      2: return (v >= 100) ? pat(v / 100) : 7'h00;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_disp();
    @(negedge clk);
    #1 disp_clk = 1'b1;
    #2 disp_clk = 1'b0;
    #1;
    idx_exp = (idx_exp + 1) % 4;
  endtask

  task automatic load_val(input int v);
    @(negedge clk);
    bus_i = 8'(v);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    bus_i = ~8'(v);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset enable", {7'h0, dig_en_o}, {7'h0, 4'b0001});
    chk("R1 reset segments", {4'h0, seg_o}, {4'h0, 7'h3F});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 no advance on clk", {7'h0, dig_en_o}, {7'h0, 4'b0001});

    for (int v = 0; v < 256; v++) begin
      load_val(v);
      for (int k = 0; k < 4; k++) begin
        chk("R3 enable one-hot R2", {7'h0, dig_en_o}, {7'h0, 4'(1 << idx_exp)});
        chk("R4 R6 R7 R8 R9 R10 segments", {4'h0, seg_o}, {4'h0, exp_seg(v, idx_exp)});
        step_disp();
      end
    end

    load_val(207);
    repeat (5) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R5 hold after strobe", {4'h0, seg_o}, {4'h0, exp_seg(207, idx_exp)});
      step_disp();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule